// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs a single read or write transfer on an external asynchronous memory or peripheral bus. An internal requester presents an address, write data, a direction bit and a chip-select index. The sequencer then steps the external pins through five phases in a fixed order: address, setup, strobe, hold and recovery. Each chip select has its own 32-bit timing word. That word sets the length of every phase and selects between multiplexed and plain addressing. It can also turn on a ready handshake for host-port style devices.

In multiplexed mode the low address half shares the data bus and is qualified by an address latch enable. The upper address bits stay on the address pins. In host-port mode an asynchronous ready input passes through a two-flop synchronizer. The strobe phase is then held until that synchronized ready is seen high. When recovery ends, the requester gets a one-cycle completion pulse with the captured read data.

Top module: `xbus_seq`

## Requirements
- R1: While and right after reset, req_ready is high; done, ext_ale, ext_rd_n/ext_wr_n strobes, ext_data_oe, ext_addr and ext_data_out show their idle values (strobes and every ext_cs_n high, the rest zero).
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. The outputs of address cycle 0 appear right after that edge, and the phases follow as address, setup, strobe, hold, recovery, with no gap between them.
- R3: The address phase lasts 1+A clocks in plain mode and 2+A clocks in multiplexed mode, where A is timing bits [29:28]. ext_ale is high for all but its last cycle, or for its only cycle when it lasts one clock, and is low in every other phase.
- R4: In multiplexed mode (timing bit 1 set), ext_addr carries {addr[23:16], 16'h0} for the whole access. While ext_ale is high, the data bus drives addr[15:0] with ext_data_oe high. In the remaining address cycles it drives write data for a write and is released for a read.
- R5: In plain mode (timing bit 1 clear), ext_addr carries the full 24-bit address, unchanged from the first address cycle to the last recovery cycle.
- R6: The ext_cs_n line selected by req_cs is low from the first setup cycle through the last hold cycle, and every other line stays high. All lines are high in the address and recovery phases. Setup lasts 1+S clocks, where S is timing bits [27:26].
- R7: The strobe phase drives ext_wr_n low for a write or ext_rd_n low for a read, for T clocks, where T is timing bits [25:22] and a value of 0 counts as 1. The other strobe stays high.
- R8: For a write, ext_data_oe is high with the write data on ext_data_out from the end of the address-latch cycles through the last hold cycle. For a read it is low outside multiplexed address latching. Recovery (1+V clocks, V = bits [19:16]) and hold (1+H clocks, H = bits [21:20]) never drive strobes.
- R9: For a read, the value on ext_data_in during the last strobe cycle appears on rdata in the cycle where done is high.
- R10: In host-port mode (timing bit 0 set), the strobe phase ends at the first cycle that is at least its programmed length and in which the two-flop synchronized ext_rdy is high. If ext_rdy rises during strobe cycle s, the strobe lasts max(T, s+3) clocks. Outside host-port mode ext_rdy has no effect.
- R11: The timing word of chip select i is bits [32*i+31:32*i] of cs_timing, and each access uses the word of its own chip select.
- R12: done is high for exactly one clock, the cycle after the last recovery cycle, and req_ready is low from the first address cycle through the last recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW (2) | Chip-select index |
| req_addr | input | AW (24) | Transfer address |
| req_wdata | input | DW (16) | Write data |
| cs_timing | input | 32*NCS (128) | Per chip select timing words |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Captured read data |
| ext_addr | output | AW (24) | External address pins |
| ext_ale | output | 1 | Address latch enable |
| ext_cs_n | output | NCS (4) | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_data_out | output | DW (16) | Data bus output value |
| ext_data_oe | output | 1 | Data bus output enable |
| ext_data_in | input | DW (16) | Data bus input value |
| ext_rdy | input | 1 | Asynchronous device ready |

## Verification
Every cycle of every transfer is compared with a waveform predicted from the phase lengths. This covers plain and multiplexed addressing, both directions, and address extensions from 0 to 3, so the ALE length and the address-to-data switch on the shared bus are pinned down. Strobe fields of 0, 1 and 15 and long recovery separate the "0 counts as 1" rule from off-by-one phase counters. The data-in value changes every cycle, so a capture one cycle early or late is visible in rdata. Host-port transfers raise ready before, inside and after the programmed strobe window, which tells synchronizer depth errors apart from a strobe that ignores its minimum length. Plain transfers hold ready at random levels to show it is ignored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } xbus_phase_e;

  typedef struct packed {
    logic [1:0] t_addr;
    logic [1:0] t_setup;
    logic [3:0] t_strobe;
    logic [1:0] t_hold;
    logic [3:0] t_recov;
    logic       muxed;
    logic       hostport;
  } xbus_cfg_t;

  localparam int TWORD_W = 32;
  localparam int CNT_W   = 5;

  // Field positions within one chip-select timing word
  function automatic xbus_cfg_t cfg_unpack(input logic [TWORD_W-1:0] w);
    xbus_cfg_t c;
    c.t_addr   = w[29:28];
    c.t_setup  = w[27:26];
    c.t_strobe = w[25:22];
    c.t_hold   = w[21:20];
    c.t_recov  = w[19:16];
    c.muxed    = w[1];
    c.hostport = w[0];
    return c;
  endfunction

  // Number of clocks a phase lasts (before any ready stretch)
  function automatic logic [CNT_W-1:0] phase_len(input xbus_phase_e ph, input xbus_cfg_t c);
    logic [CNT_W-1:0] n;
    case (ph)
      PH_ADDR:   n = {3'b000, c.t_addr} + (c.muxed ? 5'd2 : 5'd1);
      PH_SETUP:  n = 5'd1 + {3'b000, c.t_setup};
      PH_STROBE: n = (c.t_strobe == 4'd0) ? 5'd1 : {1'b0, c.t_strobe};
      PH_HOLD:   n = 5'd1 + {3'b000, c.t_hold};
      PH_RECOV:  n = 5'd1 + {1'b0, c.t_recov};
      default:   n = 5'd1;
    endcase
    return n;
  endfunction

  function automatic xbus_phase_e phase_next(input xbus_phase_e ph);
    xbus_phase_e n;
    case (ph)
      PH_ADDR:   n = PH_SETUP;
      PH_SETUP:  n = PH_STROBE;
      PH_STROBE: n = PH_HOLD;
      PH_HOLD:   n = PH_RECOV;
      default:   n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_tsel.sv
module xbus_tsel import xbus_pkg::*; #(
  parameter int NCS = 4,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [NCS*TWORD_W-1:0] timing_flat,
  input  logic [CSW-1:0]         sel,
  output xbus_cfg_t              cfg
);

  xbus_cfg_t cfg_arr [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_unpack
    assign cfg_arr[g] = cfg_unpack(timing_flat[g*TWORD_W +: TWORD_W]);
  end

  assign cfg = cfg_arr[sel];

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm import xbus_pkg::*; #(
  parameter int NCS = 4,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  parameter int AW  = 24,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  xbus_cfg_t      req_cfg,
  input  logic           rdy_sync,
  input  logic [DW-1:0]  ext_data_in,
  output logic           req_ready,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [AW-1:0]  ext_addr,
  output logic           ext_ale,
  output logic [NCS-1:0] ext_cs_n,
  output logic           ext_rd_n,
  output logic           ext_wr_n,
  output logic [DW-1:0]  ext_data_out,
  output logic           ext_data_oe
);

  xbus_phase_e      ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, len_cur, la;
  logic             last, accept;

  // transfer context latched at accept
  logic             wr_q;
  logic [CSW-1:0]   cs_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  xbus_cfg_t        cfg_q;

  // context seen by the output decode
  logic             e_wr;
  logic [CSW-1:0]   e_cs;
  logic [AW-1:0]    e_addr;
  logic [DW-1:0]    e_wdata;
  xbus_cfg_t        e_cfg;

  // next-cycle output values
  logic [AW-1:0]    o_addr;
  logic             o_ale, o_rd_n, o_wr_n, o_oe;
  logic [NCS-1:0]   o_cs_n;
  logic [DW-1:0]    o_dout;

  assign accept  = (ph_q == PH_IDLE) && req_valid;
  assign len_cur = phase_len(ph_q, cfg_q);
  assign last    = (cnt_q == len_cur - 5'd1);

  assign e_wr    = accept ? req_write : wr_q;
  assign e_cs    = accept ? req_cs    : cs_q;
  assign e_addr  = accept ? req_addr  : addr_q;
  assign e_wdata = accept ? req_wdata : wdata_q;
  assign e_cfg   = accept ? req_cfg   : cfg_q;

  // phase stepping
  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (req_valid) begin
        ph_n  = PH_ADDR;
        cnt_n = '0;
      end
    end else if (!last) begin
      cnt_n = cnt_q + 5'd1;
    end else if ((ph_q != PH_STROBE) || !cfg_q.hostport || rdy_sync) begin
      ph_n  = phase_next(ph_q);
      cnt_n = '0;
    end
  end

  // pin decode of the cycle about to start
  always_comb begin
    o_addr = '0;
    o_ale  = 1'b0;
    o_cs_n = '1;
    o_rd_n = 1'b1;
    o_wr_n = 1'b1;
    o_oe   = 1'b0;
    o_dout = '0;
    la     = phase_len(PH_ADDR, e_cfg);
    if (ph_n != PH_IDLE)
      o_addr = e_cfg.muxed ? {e_addr[AW-1:DW], {DW{1'b0}}} : e_addr;
    case (ph_n)
      PH_ADDR: begin
        o_ale = (la == 5'd1) || (cnt_n < la - 5'd1);
        if (e_cfg.muxed && o_ale) begin
          o_oe   = 1'b1;
          o_dout = e_addr[DW-1:0];
        end else if (e_wr) begin
          o_oe   = 1'b1;
          o_dout = e_wdata;
        end
      end
      PH_SETUP, PH_HOLD: begin
        o_cs_n[e_cs] = 1'b0;
        if (e_wr) begin
          o_oe   = 1'b1;
          o_dout = e_wdata;
        end
      end
      PH_STROBE: begin
        o_cs_n[e_cs] = 1'b0;
        if (e_wr) begin
          o_wr_n = 1'b0;
          o_oe   = 1'b1;
          o_dout = e_wdata;
        end else begin
          o_rd_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q         <= PH_IDLE;
      cnt_q        <= '0;
      wr_q         <= 1'b0;
      cs_q         <= '0;
      addr_q       <= '0;
      wdata_q      <= '0;
      cfg_q        <= '0;
      done         <= 1'b0;
      rdata        <= '0;
      ext_addr     <= '0;
      ext_ale      <= 1'b0;
      ext_cs_n     <= '1;
      ext_rd_n     <= 1'b1;
      ext_wr_n     <= 1'b1;
      ext_data_out <= '0;
      ext_data_oe  <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      if (accept) begin
        wr_q    <= req_write;
        cs_q    <= req_cs;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        cfg_q   <= req_cfg;
      end
      if ((ph_q == PH_STROBE) && (ph_n == PH_HOLD) && !wr_q)
        rdata <= ext_data_in;
      done         <= (ph_q == PH_RECOV) && (ph_n == PH_IDLE);
      ext_addr     <= o_addr;
      ext_ale      <= o_ale;
      ext_cs_n     <= o_cs_n;
      ext_rd_n     <= o_rd_n;
      ext_wr_n     <= o_wr_n;
      ext_data_out <= o_dout;
      ext_data_oe  <= o_oe;
    end
  end

  assign req_ready = (ph_q == PH_IDLE);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int NCS         = 4,
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CSW        = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [CSW-1:0]         req_cs,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [NCS*TWORD_W-1:0] cs_timing,
  output logic                   req_ready,
  output logic                   done,
  output logic [DW-1:0]          rdata,
  output logic [AW-1:0]          ext_addr,
  output logic                   ext_ale,
  output logic [NCS-1:0]         ext_cs_n,
  output logic                   ext_rd_n,
  output logic                   ext_wr_n,
  output logic [DW-1:0]          ext_data_out,
  output logic                   ext_data_oe,
  input  logic [DW-1:0]          ext_data_in,
  input  logic                   ext_rdy
);

  xbus_cfg_t sel_cfg;
  logic      rdy_s;

  xbus_tsel #(.NCS(NCS), .CSW(CSW)) u_tsel (
    .timing_flat (cs_timing),
    .sel         (req_cs),
    .cfg         (sel_cfg)
  );

  xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_rdy),
    .sync_out (rdy_s)
  );

  xbus_fsm #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_cs       (req_cs),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_cfg      (sel_cfg),
    .rdy_sync     (rdy_s),
    .ext_data_in  (ext_data_in),
    .req_ready    (req_ready),
    .done         (done),
    .rdata        (rdata),
    .ext_addr     (ext_addr),
    .ext_ale      (ext_ale),
    .ext_cs_n     (ext_cs_n),
    .ext_rd_n     (ext_rd_n),
    .ext_wr_n     (ext_wr_n),
    .ext_data_out (ext_data_out),
    .ext_data_oe  (ext_data_oe)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           req_ready,
  input logic           done,
  input logic [AW-1:0]  ext_addr,
  input logic           ext_ale,
  input logic [NCS-1:0] ext_cs_n,
  input logic           ext_rd_n,
  input logic           ext_wr_n,
  input logic           ext_data_oe
);

  // R6
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  // R6
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

  // R3
  ale_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ext_ale |-> (&ext_cs_n));

  // R8
  read_released_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_data_oe);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !(&ext_cs_n) |-> !req_ready);

  // R5
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&ext_cs_n) && $past(!(&ext_cs_n))) |-> $stable(ext_addr));

endmodule

bind xbus_seq xbus_seq_chk #(.NCS(NCS), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .done        (done),
  .ext_addr    (ext_addr),
  .ext_ale     (ext_ale),
  .ext_cs_n    (ext_cs_n),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .ext_data_oe (ext_data_oe)
);

// File: tb/test_xbus_seq.sv
module test_xbus_seq;

  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [1:0]     req_cs = '0;
  logic [AW-1:0]  req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic [31:0]    tw [NCS];
  logic [NCS*32-1:0] cs_timing;
  logic           req_ready, done;
  logic [DW-1:0]  rdata;
  logic [AW-1:0]  ext_addr;
  logic           ext_ale;
  logic [NCS-1:0] ext_cs_n;
  logic           ext_rd_n, ext_wr_n;
  logic [DW-1:0]  ext_data_out;
  logic           ext_data_oe;
  logic [DW-1:0]  ext_data_in = '0;
  logic           ext_rdy = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  assign cs_timing = {tw[3], tw[2], tw[1], tw[0]};

  always #10 clk = ~clk;

  xbus_seq i_xbus_seq (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
    .req_cs (req_cs), .req_addr (req_addr), .req_wdata (req_wdata),
    .cs_timing (cs_timing), .req_ready (req_ready), .done (done), .rdata (rdata),
    .ext_addr (ext_addr), .ext_ale (ext_ale), .ext_cs_n (ext_cs_n),
    .ext_rd_n (ext_rd_n), .ext_wr_n (ext_wr_n), .ext_data_out (ext_data_out),
    .ext_data_oe (ext_data_oe), .ext_data_in (ext_data_in), .ext_rdy (ext_rdy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // timing word per R11 field positions
  function automatic logic [31:0] mk_tw(int a, int s, int t, int h, int v, bit mux, bit hp);
    logic [31:0] w = '0;
    w[29:28] = 2'(a); w[27:26] = 2'(s); w[25:22] = 4'(t);
    w[21:20] = 2'(h); w[19:16] = 4'(v); w[1] = mux; w[0] = hp;
    return w;
  endfunction

  function automatic logic [49:0] pins_now();
    return {ext_addr, ext_ale, ext_cs_n, ext_rd_n, ext_wr_n, ext_data_oe, ext_data_out, done, req_ready};
  endfunction

  // raise: strobe cycle in which ready rises (host-port only)
  task automatic run_access(input bit wr, input logic [23:0] addr, input logic [15:0] wd,
                            input int cs, input int raise, input bit idle_rdy);
    logic [31:0] w = tw[cs];
    bit mux = w[1];
    bit hp  = w[0];
    int la  = (mux ? 2 : 1) + int'(w[29:28]);
    int ls  = 1 + int'(w[27:26]);
    int l3  = (w[25:22] == 0) ? 1 : int'(w[25:22]);
    int lt  = (hp && raise + 3 > l3) ? raise + 3 : l3;
    int lh  = 1 + int'(w[21:20]);
    int lr  = 1 + int'(w[19:16]);
    int ks  = la + ls;
    int total = la + ls + lt + lh + lr;
    logic [15:0] din_base = 16'($urandom);
    logic [15:0] exp_rd = '0;
    logic [23:0] pin_addr = mux ? {addr[23:16], 16'h0} : addr;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_cs = 2'(cs);
    ext_rdy = hp ? 1'b0 : idle_rdy;
    for (int k = 0; k < total; k++) begin
      logic [49:0] e;
      logic ale, rdn, wrn, oe;
      logic [3:0] csn;
      logic [15:0] dout;
      string tag;
      int o;
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      ext_data_in = din_base ^ {k[7:0], k[7:0]};
      if (hp && k == ks + raise) ext_rdy = 1'b1;
      if (k == ks + lt - 1) exp_rd = ext_data_in;
      ale = 0; rdn = 1; wrn = 1; oe = 0; csn = 4'hF; dout = '0;
      o = k;
      if (o < la) begin
        tag = "R3/R4/R5";
        ale = (la == 1) || (o < la - 1);
        if (mux && ale) begin oe = 1; dout = addr[15:0]; end
        else if (wr) begin oe = 1; dout = wd; end
      end else if (o < la + ls + lt + lh) begin
        tag = (o >= ks && o < ks + lt) ? "R7/R10/R11" : "R6/R8";
        csn[cs] = 1'b0;
        if (wr) begin oe = 1; dout = wd; end
        if (o >= ks && o < ks + lt) begin
          if (wr) wrn = 0; else rdn = 0;
        end
      end else begin
        tag = "R2/R6/R12";
      end
      e = {pin_addr, ale, csn, rdn, wrn, oe, dout, 1'b0, 1'b0};
      check(pins_now() == e, tag, 64'(pins_now()), 64'(e));
    end
    @(negedge clk);
    check(done === 1'b1 && req_ready === 1'b1, "R12 done pulse", {62'd0, done, req_ready}, 64'd3);
    if (!wr) check(rdata == exp_rd, "R9 read capture", 64'(rdata), 64'(exp_rd));
    @(negedge clk);
    check(done === 1'b0, "R12 done single", 64'(done), 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < NCS; i++) tw[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(pins_now() == {24'h0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1}, "R1 reset",
          64'(pins_now()), 64'({24'h0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1}));
    rst = 1'b0;
    @(negedge clk);
    check(pins_now() == {24'h0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1}, "R1 after reset",
          64'(pins_now()), 64'({24'h0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1}));

    // directed corners: R3 R4 R5 R7 R11
    tw[0] = mk_tw(0, 0, 1, 0, 0, 0, 0);
    tw[1] = mk_tw(0, 1, 2, 1, 2, 1, 0);
    tw[2] = mk_tw(3, 3, 0, 3, 15, 1, 0);
    tw[3] = mk_tw(3, 0, 15, 0, 1, 0, 0);
    run_access(1, 24'hA5C3E1, 16'h1234, 0, 0, 1);
    run_access(0, 24'h123456, 16'h0000, 0, 0, 0);
    run_access(0, 24'hFEDCBA, 16'h0000, 1, 0, 1);
    run_access(1, 24'h0F0F0F, 16'hBEEF, 2, 0, 0);
    run_access(0, 24'h800001, 16'h0000, 2, 0, 1);
    run_access(1, 24'h7FFFFE, 16'hCAFE, 3, 0, 1);
    // R10 host-port: ready early, late, and inside a long strobe
    tw[1] = mk_tw(2, 2, 1, 0, 1, 0, 1);
    tw[2] = mk_tw(2, 2, 8, 1, 0, 1, 1);
    run_access(0, 24'h111111, 16'h0, 1, 0, 0);
    run_access(0, 24'h222222, 16'h0, 1, 6, 0);
    run_access(1, 24'h333333, 16'h5A5A, 1, 2, 0);
    run_access(0, 24'h444444, 16'h0, 2, 1, 0);
    run_access(0, 24'h555555, 16'h0, 2, 9, 0);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int c = int'($urandom_range(0, NCS - 1));
      bit hp = ($urandom_range(0, 3) == 0);
      int a = int'($urandom_range(0, 3));
      int s = int'($urandom_range(0, 3));
      int t = int'($urandom_range(0, 15));
      if (hp) begin
        if (a < 2) a = 2;
        if (s < 2) s = 2;
        if (t < 1) t = 1;
      end
      tw[c] = mk_tw(a, s, t, int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                    1'($urandom_range(0, 1)), hp);
      run_access(1'($urandom_range(0, 1)), 24'($urandom), 16'($urandom), c,
                 int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule